// File: doc/BRIEF.md
# Lookup-Table Breakpoint Unit

This block watches several internal buses of a processor and raises a trap when a watched value has been marked. Each bus value addresses a lookup memory of its own, with one 8-bit match word per entry. The matching rule is therefore whatever the table holds. It can be one value, a range or any scattered set, and a range is just every entry in it marked. Bits 4..0 of a match word can raise a trap directly. Bits 7..5 are link bits. The link bits of all bus tables are joined into an address for a second-level combining table, and that table flags conditions that must hold on several buses at once.

A debugger loads the tables while the processor is halted. It uses a port that reads an entry and writes it back with one bit set or toggled. A sweep engine clears or fills one table or all of them in a single pass, so that no per-entry commands are needed. In coverage mode, every executed cycle sets a chosen bit in the entry addressed by each bus. A forwarding path keeps that bit when the same value repeats on back-to-back cycles.

The default table index is 8 bits wide. A full 16-bit bus uses `IDX_W = 16`.

Top module: `bpu_top`

## Requirements
- R1: After reset, `trapOut`, `sweepBusy` and `sweepDone` are 0 and the trap-enable mask is all zeros. Because of the cleared mask, entries that are all ones cause no trap until the mask is loaded.
- R2: Bus table t is addressed by bits `busVals[t*IDX_W +: IDX_W]`. If bit b (b in 0..4) of the addressed entry is set and mask bit `5*t+b` is set, `trapOut` rises after the second rising edge following the cycle in which `busValid` is high, and `trapSrc` equals t.
- R3: Marking every entry of a value range makes each value inside the range trap. Values just outside the range do not trap.
- R4: Bits 7..5 of the addressed entry of table t form bits `3*t+2 .. 3*t` of the combining-table address. If bit c of the combining entry is set and mask bit `5*NBUS+c` is set, a trap rises one cycle later than a direct trap would, with `trapSrc` equal to NBUS.
- R5: The trap stays high, with `trapSrc` unchanged, until `trapAck` is pulsed. When several tables fire together, the lowest table index is reported.
- R6: A pulse on `dbgWe` is accepted only while `cpuHalted` is high and no sweep is running. It reads entry `dbgAddr` of table `dbgSel`, then writes it back with bit `dbgBit` set (`dbgToggle`=0) or inverted (`dbgToggle`=1). A pulse while the processor runs has no effect.
- R7: `sweepStart` while halted writes every address from 0 up to all ones of the widest table address. It writes all ones (`sweepFill`=1) or zeros, into table `sweepSel` or into every table (`sweepAll`=1). `sweepBusy` stays high for 2^AW_MAX cycles, `sweepDone` pulses for one cycle at the end, and debug writes during the sweep are ignored.
- R8: With `covEn` high, each matched cycle sets bit `covBit` in the addressed entry of every bus table. A value repeated on the next cycle already sees that bit.
- R9: A set table bit whose mask bit is clear never raises a trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busVals | input | NBUS*IDX_W | Watched bus values, table 0 in the low bits |
| busValid | input | 1 | Watched values belong to an executed cycle |
| cpuHalted | input | 1 | Processor is stopped |
| maskWe | input | 1 | Load the trap-enable mask |
| maskIn | input | 5*NBUS+8 | New mask value |
| dbgWe | input | 1 | Start a debug bit write |
| dbgSel | input | SEL_W | Table selected for the debug write (NBUS = combining table) |
| dbgAddr | input | AW_MAX | Entry address for the debug write |
| dbgBit | input | 3 | Bit to set or toggle |
| dbgToggle | input | 1 | 1 toggles the bit, 0 sets it |
| sweepStart | input | 1 | Start a sweep |
| sweepAll | input | 1 | Sweep every table |
| sweepSel | input | SEL_W | Table to sweep when not sweeping all |
| sweepFill | input | 1 | 1 writes all ones, 0 writes zeros |
| covEn | input | 1 | Coverage marking on |
| covBit | input | 3 | Bit marked in coverage mode |
| trapAck | input | 1 | Acknowledge and clear the trap |
| trapOut | output | 1 | Held trap request |
| trapSrc | output | SEL_W | Index of the table that fired |
| sweepBusy | output | 1 | Sweep running |
| sweepDone | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
A corrupted table entry or link bit shows at the ports as a trap that is missing or out of place. A direct trap is visible two edges after the value, and a combined trap one edge later. A wrong mask or a wrong priority encoder gives a wrong `trapSrc` on the same edge. A faulty sweep counter shows as a `sweepBusy` length other than 2^AW_MAX cycles, or as entries left unwritten. A missing forwarding path shows only when a value is repeated back to back, as a trap that never comes on the edge where it should.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int WORD_W = 8;
  localparam int DIR_W  = 5;
  localparam int LINK_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_DRD, ST_DWR, ST_SWEEP} bpuState_t;

  typedef struct packed {
    logic matchEn;
    logic rdDbg;
    logic dbgWr;
    logic sweepWr;
    logic fillOnes;
    logic toggle;
    logic sweepAll;
  } bpuStrobe_t;
endpackage

// File: rtl/bpu_lut.sv
module bpu_lut #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1<<AW];

  // a write to the entry being read is forwarded to the read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= (we && waddr == raddr) ? wdata : mem[raddr];
  end
endmodule

// File: rtl/bpu_ctrl.sv
module bpu_ctrl import bpu_pkg::*; #(
  parameter int NBUS   = 3,
  parameter int AW_MAX = 9,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              cpuHalted,
  input  logic              dbgWe,
  input  logic [SEL_W-1:0]  dbgSel,
  input  logic [AW_MAX-1:0] dbgAddr,
  input  logic [2:0]        dbgBit,
  input  logic              dbgToggle,
  input  logic              sweepStart,
  input  logic              sweepAll,
  input  logic [SEL_W-1:0]  sweepSel,
  input  logic              sweepFill,
  input  logic [NBUS:0]     hitVec,
  input  logic              trapAck,
  output bpuStrobe_t        strobe,
  output logic [AW_MAX-1:0] ctlAddr,
  output logic [SEL_W-1:0]  ctlSel,
  output logic [2:0]        ctlBit,
  output logic              trapOut,
  output logic [SEL_W-1:0]  trapSrc,
  output logic              sweepBusy,
  output logic              sweepDone
);
  bpuState_t stateQ;
  logic togQ, allQ, fillQ;
  logic anyHit;
  logic [SEL_W-1:0] firstHit;

  assign anyHit = |hitVec;

  always_comb begin
    firstHit = '0;
    for (int t = NBUS; t >= 0; t--) begin
      if (hitVec[t]) firstHit = SEL_W'(t);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      ctlAddr   <= '0;
      ctlSel    <= '0;
      ctlBit    <= '0;
      togQ      <= 1'b0;
      allQ      <= 1'b0;
      fillQ     <= 1'b0;
      sweepDone <= 1'b0;
      trapOut   <= 1'b0;
      trapSrc   <= '0;
    end else begin
      sweepDone <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (sweepStart && cpuHalted) begin
            stateQ  <= ST_SWEEP;
            ctlAddr <= '0;
            ctlSel  <= sweepSel;
            allQ    <= sweepAll;
            fillQ   <= sweepFill;
          end else if (dbgWe && cpuHalted) begin
            stateQ  <= ST_DRD;
            ctlAddr <= dbgAddr;
            ctlSel  <= dbgSel;
            ctlBit  <= dbgBit;
            togQ    <= dbgToggle;
            allQ    <= 1'b0;
          end
        end
        ST_DRD: stateQ <= ST_DWR;
        ST_DWR: stateQ <= ST_IDLE;
        ST_SWEEP: begin
          if (ctlAddr == '1) begin
            stateQ    <= ST_IDLE;
            sweepDone <= 1'b1;
          end else begin
            ctlAddr <= ctlAddr + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase

      if (trapAck) begin
        trapOut <= anyHit;
        trapSrc <= firstHit;
      end else if (!trapOut && anyHit) begin
        trapOut <= 1'b1;
        trapSrc <= firstHit;
      end
    end
  end

  always_comb begin
    strobe.matchEn  = busValid && !cpuHalted && (stateQ == ST_IDLE);
    strobe.rdDbg    = (stateQ == ST_DRD);
    strobe.dbgWr    = (stateQ == ST_DWR);
    strobe.sweepWr  = (stateQ == ST_SWEEP);
    strobe.fillOnes = fillQ;
    strobe.toggle   = togQ;
    strobe.sweepAll = allQ;
  end
  assign sweepBusy = (stateQ == ST_SWEEP);

  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    trapOut && !trapAck |=> trapOut && $stable(trapSrc)); // R5
  AST_DONE_ENDS_SWEEP: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> $past(sweepBusy) && !sweepBusy); // R7
  AST_SWEEP_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sweepBusy) |-> $past(sweepStart && cpuHalted)); // R7
  AST_DBG_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdDbg |-> $past(dbgWe && cpuHalted && !sweepBusy)); // R6
endmodule

// File: rtl/bpu_datapath.sv
module bpu_datapath import bpu_pkg::*; #(
  parameter int NBUS   = 3,
  parameter int IDX_W  = 8,
  parameter int CMB_AW = 9,
  parameter int AW_MAX = 9,
  parameter int MASK_W = 23,
  parameter int SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bpuStrobe_t            strobe,
  input  logic [AW_MAX-1:0]     ctlAddr,
  input  logic [SEL_W-1:0]      ctlSel,
  input  logic [2:0]            ctlBit,
  input  logic [NBUS*IDX_W-1:0] busVals,
  input  logic                  maskWe,
  input  logic [MASK_W-1:0]     maskIn,
  input  logic                  covEn,
  input  logic [2:0]            covBit,
  output logic [NBUS:0]         hitVec
);
  logic [MASK_W-1:0]     maskQ;
  logic                  v1, v2;
  logic [NBUS*IDX_W-1:0] busQ;
  logic [WORD_W-1:0]     rdW [NBUS+1];
  logic [CMB_AW-1:0]     linkAddr;
  logic [WORD_W-1:0]     bitMask, covMask, fillWord;

  assign bitMask  = WORD_W'(1) << ctlBit;
  assign covMask  = WORD_W'(1) << covBit;
  assign fillWord = strobe.fillOnes ? '1 : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      v1    <= 1'b0;
      v2    <= 1'b0;
      busQ  <= '0;
    end else begin
      if (maskWe) maskQ <= maskIn;
      v1   <= strobe.matchEn;
      v2   <= v1;
      busQ <= busVals;
    end
  end

  for (genvar t = 0; t < NBUS; t++) begin : gBus
    logic             we;
    logic [IDX_W-1:0] wa, ra;
    logic [WORD_W-1:0] wd;
    logic             hitSel;

    assign hitSel = strobe.sweepAll || (ctlSel == SEL_W'(t));
    assign ra = strobe.rdDbg ? ctlAddr[IDX_W-1:0] : busVals[t*IDX_W +: IDX_W];

    always_comb begin
      we = 1'b0;
      wa = busQ[t*IDX_W +: IDX_W];
      wd = rdW[t] | covMask;
      if (strobe.sweepWr && hitSel) begin
        we = 1'b1;
        wa = ctlAddr[IDX_W-1:0];
        wd = fillWord;
      end else if (strobe.dbgWr && ctlSel == SEL_W'(t)) begin
        we = 1'b1;
        wa = ctlAddr[IDX_W-1:0];
        wd = strobe.toggle ? (rdW[t] ^ bitMask) : (rdW[t] | bitMask);
      end else if (v1 && covEn) begin
        we = 1'b1;
      end
    end

    bpu_lut #(.AW(IDX_W), .DW(WORD_W)) uLut (
      .clk(clk), .we(we), .waddr(wa), .wdata(wd), .raddr(ra), .rdata(rdW[t])
    );

    assign linkAddr[t*LINK_W +: LINK_W] = rdW[t][WORD_W-1 -: LINK_W];
    assign hitVec[t] = v1 && |(rdW[t][DIR_W-1:0] & maskQ[t*DIR_W +: DIR_W]);
  end

  logic              cWe;
  logic [CMB_AW-1:0] cAddr, cRa;
  logic [WORD_W-1:0] cWd;

  assign cRa = strobe.rdDbg ? ctlAddr[CMB_AW-1:0] : linkAddr;

  always_comb begin
    cWe   = 1'b0;
    cAddr = ctlAddr[CMB_AW-1:0];
    cWd   = fillWord;
    if (strobe.sweepWr && (strobe.sweepAll || ctlSel == SEL_W'(NBUS))) begin
      cWe = 1'b1;
    end else if (strobe.dbgWr && ctlSel == SEL_W'(NBUS)) begin
      cWe = 1'b1;
      cWd = strobe.toggle ? (rdW[NBUS] ^ bitMask) : (rdW[NBUS] | bitMask);
    end
  end

  bpu_lut #(.AW(CMB_AW), .DW(WORD_W)) uComb (
    .clk(clk), .we(cWe), .waddr(cAddr), .wdata(cWd), .raddr(cRa), .rdata(rdW[NBUS])
  );

  assign hitVec[NBUS] = v2 && |(rdW[NBUS] & maskQ[NBUS*DIR_W +: WORD_W]);

  AST_DIRECT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    |hitVec[NBUS-1:0] |-> $past(strobe.matchEn)); // R2
  AST_COMB_TWO_STAGES: assert property (@(posedge clk) disable iff (!rstN)
    hitVec[NBUS] |-> $past(strobe.matchEn, 2)); // R4
endmodule

// File: rtl/bpu_top.sv
module bpu_top import bpu_pkg::*; #(
  parameter int NBUS  = 3,
  parameter int IDX_W = 8,
  localparam int CMB_AW = LINK_W * NBUS,
  localparam int AW_MAX = (IDX_W > CMB_AW) ? IDX_W : CMB_AW,
  localparam int MASK_W = DIR_W * NBUS + WORD_W,
  localparam int SEL_W  = $clog2(NBUS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NBUS*IDX_W-1:0] busVals,
  input  logic                  busValid,
  input  logic                  cpuHalted,
  input  logic                  maskWe,
  input  logic [MASK_W-1:0]     maskIn,
  input  logic                  dbgWe,
  input  logic [SEL_W-1:0]      dbgSel,
  input  logic [AW_MAX-1:0]     dbgAddr,
  input  logic [2:0]            dbgBit,
  input  logic                  dbgToggle,
  input  logic                  sweepStart,
  input  logic                  sweepAll,
  input  logic [SEL_W-1:0]      sweepSel,
  input  logic                  sweepFill,
  input  logic                  covEn,
  input  logic [2:0]            covBit,
  input  logic                  trapAck,
  output logic                  trapOut,
  output logic [SEL_W-1:0]      trapSrc,
  output logic                  sweepBusy,
  output logic                  sweepDone
);
  bpuStrobe_t        strobe;
  logic [AW_MAX-1:0] ctlAddr;
  logic [SEL_W-1:0]  ctlSel;
  logic [2:0]        ctlBit;
  logic [NBUS:0]     hitVec;

  bpu_ctrl #(.NBUS(NBUS), .AW_MAX(AW_MAX), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .cpuHalted(cpuHalted),
    .dbgWe(dbgWe), .dbgSel(dbgSel), .dbgAddr(dbgAddr), .dbgBit(dbgBit),
    .dbgToggle(dbgToggle), .sweepStart(sweepStart), .sweepAll(sweepAll),
    .sweepSel(sweepSel), .sweepFill(sweepFill), .hitVec(hitVec),
    .trapAck(trapAck), .strobe(strobe), .ctlAddr(ctlAddr), .ctlSel(ctlSel),
    .ctlBit(ctlBit), .trapOut(trapOut), .trapSrc(trapSrc),
    .sweepBusy(sweepBusy), .sweepDone(sweepDone)
  );

  bpu_datapath #(.NBUS(NBUS), .IDX_W(IDX_W), .CMB_AW(CMB_AW), .AW_MAX(AW_MAX),
                 .MASK_W(MASK_W), .SEL_W(SEL_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctlAddr(ctlAddr),
    .ctlSel(ctlSel), .ctlBit(ctlBit), .busVals(busVals), .maskWe(maskWe),
    .maskIn(maskIn), .covEn(covEn), .covBit(covBit), .hitVec(hitVec)
  );
endmodule

// File: tb/sim_bpu_top.sv
module sim_bpu_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int IW = 8;
  localparam int AWM = 9;
  localparam int MW = 23;
  localparam int SW = 2;
  localparam int NVEC = 11;
  // {busA, busB, busC, trapAfter2Edges, trapAfter3Edges, expectedSrc}
  localparam logic [27:0] VECS [NVEC] = '{
    {8'h10, 8'h00, 8'h00, 1'b1, 1'b1, 2'd0},  // R2
    {8'h00, 8'h40, 8'h00, 1'b1, 1'b1, 2'd1},  // R3 low end
    {8'h00, 8'h43, 8'h00, 1'b1, 1'b1, 2'd1},  // R3 high end
    {8'h00, 8'h44, 8'h00, 1'b0, 1'b0, 2'd0},  // R3 above
    {8'h00, 8'h3F, 8'h00, 1'b0, 1'b0, 2'd0},  // R3 below
    {8'h00, 8'h00, 8'h99, 1'b1, 1'b1, 2'd2},  // R2 bit 4
    {8'h10, 8'h41, 8'h00, 1'b1, 1'b1, 2'd0},  // R5 priority
    {8'h30, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0},  // R6 set then toggled off
    {8'h31, 8'h00, 8'h00, 1'b1, 1'b1, 2'd0},  // R6 toggled on
    {8'h50, 8'h60, 8'h70, 1'b0, 1'b1, 2'd3},  // R4 combined
    {8'h50, 8'h60, 8'h00, 1'b0, 1'b0, 2'd0}   // R4 partial
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NB*IW-1:0] busVals = '0;
  logic busValid = 1'b0, cpuHalted = 1'b0, maskWe = 1'b0;
  logic [MW-1:0] maskIn = '0;
  logic dbgWe = 1'b0, dbgToggle = 1'b0;
  logic [SW-1:0] dbgSel = '0, sweepSel = '0;
  logic [AWM-1:0] dbgAddr = '0;
  logic [2:0] dbgBit = '0, covBit = '0;
  logic sweepStart = 1'b0, sweepAll = 1'b0, sweepFill = 1'b0, covEn = 1'b0, trapAck = 1'b0;
  logic trapOut, sweepBusy, sweepDone;
  logic [SW-1:0] trapSrc;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpu_top u0 (
    .clk(clk), .rstN(rstN), .busVals(busVals), .busValid(busValid),
    .cpuHalted(cpuHalted), .maskWe(maskWe), .maskIn(maskIn), .dbgWe(dbgWe),
    .dbgSel(dbgSel), .dbgAddr(dbgAddr), .dbgBit(dbgBit), .dbgToggle(dbgToggle),
    .sweepStart(sweepStart), .sweepAll(sweepAll), .sweepSel(sweepSel),
    .sweepFill(sweepFill), .covEn(covEn), .covBit(covBit), .trapAck(trapAck),
    .trapOut(trapOut), .trapSrc(trapSrc), .sweepBusy(sweepBusy), .sweepDone(sweepDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic run3(input logic [7:0] a, b, c, output logic t2, output logic tf, output logic [SW-1:0] s);
    busVals = {c, b, a};
    busValid = 1'b1;
    @(negedge clk);
    busValid = 1'b0;
    @(negedge clk);
    t2 = trapOut;
    @(negedge clk);
    tf = trapOut;
    s = trapSrc;
  endtask

  task automatic ackTrap();
    trapAck = 1'b1;
    @(negedge clk);
    trapAck = 1'b0;
    @(negedge clk);
  endtask

  task automatic dbgWrite(input int sel, input int addr, input int bitNo, input bit tog);
    dbgSel = SW'(sel);
    dbgAddr = AWM'(addr);
    dbgBit = 3'(bitNo);
    dbgToggle = tog;
    dbgWe = 1'b1;
    @(negedge clk);
    dbgWe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic setMask(input logic [MW-1:0] m);
    maskIn = m;
    maskWe = 1'b1;
    @(negedge clk);
    maskWe = 1'b0;
  endtask

  task automatic sweep(input bit all, input int sel, input bit fill, output int n);
    sweepAll = all;
    sweepSel = SW'(sel);
    sweepFill = fill;
    sweepStart = 1'b1;
    @(negedge clk);
    sweepStart = 1'b0;
    n = 0;
    while (sweepBusy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic t2, tf;
    logic [SW-1:0] s;
    int n;

    doReset();
    check(trapOut == 1'b0, "R1 trapOut after reset", trapOut, 0);
    check(sweepBusy == 1'b0, "R1 sweepBusy after reset", sweepBusy, 0);
    check(sweepDone == 1'b0, "R1 sweepDone after reset", sweepDone, 0);

    // R7 fill everything, measure sweep length and done pulse
    cpuHalted = 1'b1;
    sweep(1'b1, 0, 1'b1, n);
    check(n == (1 << AWM), "R7 sweep busy length", n, 1 << AWM);
    check(sweepDone == 1'b1, "R7 done pulse", sweepDone, 1);
    @(negedge clk);
    check(sweepDone == 1'b0, "R7 done lasts one cycle", sweepDone, 0);

    // R1 reset clears the mask: filled tables cause no trap
    doReset();
    cpuHalted = 1'b0;
    run3(8'h10, 8'h20, 8'h30, t2, tf, s);
    check(tf == 1'b0, "R1 no trap with cleared mask", tf, 0);
    setMask('1);
    run3(8'h10, 8'h20, 8'h30, t2, tf, s);
    check(tf == 1'b1 && s == 0, "R7 fill makes entries trap", {tf, s}, 4);
    ackTrap();

    // R7 clear all
    cpuHalted = 1'b1;
    sweep(1'b1, 0, 1'b0, n);
    cpuHalted = 1'b0;
    run3(8'h10, 8'h20, 8'h30, t2, tf, s);
    check(tf == 1'b0, "R7 clear sweep empties tables", tf, 0);

    // load the tables through the debug port
    cpuHalted = 1'b1;
    dbgWrite(0, 'h10, 0, 1'b0);
    for (int a = 'h40; a <= 'h43; a++) dbgWrite(1, a, 1, 1'b0);
    dbgWrite(2, 'h99, 4, 1'b0);
    dbgWrite(0, 'h30, 2, 1'b0);
    dbgWrite(0, 'h30, 2, 1'b1);
    dbgWrite(0, 'h31, 0, 1'b1);
    dbgWrite(0, 'h50, 5, 1'b0);
    dbgWrite(1, 'h60, 6, 1'b0);
    dbgWrite(2, 'h70, 7, 1'b0);
    dbgWrite(3, 'h111, 3, 1'b0);
    cpuHalted = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VECS[i];
      run3(v[27:20], v[19:12], v[11:4], t2, tf, s);
      check(t2 == v[3], $sformatf("R2 R3 R4 R6 vec %0d timing", i), t2, v[3]);
      check(tf == v[2], $sformatf("R2 R3 R4 R6 vec %0d trap", i), tf, v[2]);
      if (v[2]) check(s == v[1:0], $sformatf("R5 vec %0d source", i), s, v[1:0]);
      ackTrap();
    end

    // R5 trap held until acknowledged, source frozen
    run3(8'h10, 8'h00, 8'h00, t2, tf, s);
    repeat (3) @(negedge clk);
    check(trapOut == 1'b1, "R5 trap held", trapOut, 1);
    run3(8'h00, 8'h00, 8'h99, t2, tf, s);
    check(trapOut == 1'b1 && trapSrc == 0, "R5 source held", trapSrc, 0);
    ackTrap();
    check(trapOut == 1'b0, "R5 ack clears", trapOut, 0);

    // R9 masked bit does not trap
    setMask({MW{1'b1}} & ~MW'(1));
    run3(8'h10, 8'h00, 8'h00, t2, tf, s);
    check(tf == 1'b0, "R9 masked bit ignored", tf, 0);
    setMask('1);

    // R6 debug write ignored while running
    dbgWrite(0, 'h80, 0, 1'b0);
    run3(8'h80, 8'h00, 8'h00, t2, tf, s);
    check(tf == 1'b0, "R6 write while running ignored", tf, 0);

    // R7 single-table fill; debug write during sweep ignored
    cpuHalted = 1'b1;
    sweepAll = 1'b0;
    sweepSel = 2'd2;
    sweepFill = 1'b1;
    sweepStart = 1'b1;
    @(negedge clk);
    sweepStart = 1'b0;
    dbgWrite(0, 'h81, 0, 1'b0);
    n = 0;
    while (sweepBusy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    cpuHalted = 1'b0;
    run3(8'h81, 8'h05, 8'h22, t2, tf, s);
    check(tf == 1'b1 && s == 2, "R7 only selected table filled, dbg ignored", {tf, s}, 6);
    ackTrap();
    cpuHalted = 1'b1;
    sweep(1'b0, 2, 1'b0, n);
    cpuHalted = 1'b0;

    // R8 coverage marking
    covBit = 3'd2;
    covEn = 1'b1;
    run3(8'hA0, 8'hA1, 8'hA2, t2, tf, s);
    check(tf == 1'b0, "R8 first visit no trap", tf, 0);
    covEn = 1'b0;
    run3(8'hA0, 8'hB1, 8'hB2, t2, tf, s);
    check(tf == 1'b1 && s == 0, "R8 coverage bit recorded", {tf, s}, 4);
    ackTrap();
    covEn = 1'b1;
    busVals = {8'hC2, 8'hC1, 8'hC0};
    busValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busValid = 1'b0;
    @(negedge clk);
    check(trapOut == 1'b1 && trapSrc == 0, "R8 back-to-back forwarding", {trapOut, trapSrc}, 4);
    covEn = 1'b0;
    ackTrap();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule